// File: doc/BRIEF.md
# Decimal and ASCII Adjust Unit

This unit corrects a 16-bit accumulator after an ordinary binary add or subtract has been run on BCD data. It supports four operations. Two are packed operations, which hold two BCD digits per byte and adjust only the low byte. Two are unpacked operations, which hold one digit per byte and carry into, or borrow from, the high byte. The corrections are the conditional nibble fix-ups of ±06h and ±60h. They are selected by the auxiliary carry (AF) and carry (CF) that the preceding arithmetic produced.

The caller presents the accumulator, the two incoming flags and an operation code, and raises `valid_in` for one cycle. On the next clock edge the unit registers the corrected accumulator and the new AF and CF, and raises `done` for one cycle. The outputs then hold their values until the next strobe.

Top module: `bcd_adjust_unit`

## Requirements
- R1: After reset, `acc_out`, `af_out`, `cf_out` and `done` are all 0.
- R2: `done` is high for exactly one cycle, in the cycle after a cycle with `valid_in` high. While `valid_in` stays low, `acc_out`, `af_out` and `cf_out` hold their values.
- R3: Every operation uses the digit condition, which is true when the low nibble of the low byte (bits 3:0) is above 9 or `af_in` is 1. The new AF equals this condition in every operation.
- R4: For op=00 (packed add), apply two steps in order. First, if the digit condition holds, add 06h to the low byte modulo 256. Second, if the incoming low byte is above 99h or `cf_in` is 1, add 60h and set CF; otherwise clear CF. The high byte passes through unchanged. Example: low byte 0Fh gives 15h.
- R5: For op=01 (packed subtract), apply the same two steps, but subtract 06h and 60h instead of adding them. Example: low byte FFh gives 99h with CF=1.
- R6: For op=10 (unpacked add), when the digit condition holds, add 06h to the low byte, add 1 to the high byte and set CF. Otherwise leave both bytes and clear CF. Example: 000Fh gives 0105h.
- R7: For op=11 (unpacked subtract), when the digit condition holds, subtract 06h from the low byte, subtract 1 from the high byte and set CF. Otherwise leave both bytes and clear CF. Example: 02FFh gives 0109h.
- R8: The unpacked operations always clear bits 7:4 of the low byte of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Strobe that starts an adjust |
| op | input | 2 | Operation: 00 packed add, 01 packed sub, 10 unpacked add, 11 unpacked sub |
| acc_in | input | 16 | Accumulator before adjust (high byte 15:8, low byte 7:0) |
| af_in | input | 1 | Incoming auxiliary carry |
| cf_in | input | 1 | Incoming carry |
| acc_out | output | 16 | Corrected accumulator |
| af_out | output | 1 | Updated auxiliary carry |
| cf_out | output | 1 | Updated carry |
| done | output | 1 | One-cycle pulse when a result is presented |

## Verification
The only state the unit holds is its result register and the done flag. Any error in the correction logic therefore shows at the ports in the cycle right after the strobe, as a wrong byte or a wrong flag. A stuck or stale register shows as outputs that either change without a strobe or fail to change after one. The sweep covers every low byte, both incoming flags, all four operations and several high bytes. This is enough to catch a threshold that is off by one, a correction applied in the wrong direction, or a slip in the high-byte carry.

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_in,
  input  logic [1:0]  op,
  input  logic [15:0] acc_in,
  input  logic        af_in,
  input  logic        cf_in,
  output logic [15:0] acc_out,
  output logic        af_out,
  output logic        cf_out,
  output logic        done
);
  logic [7:0] lo, hi, lo_step, lo_dec, hi_unp;
  logic       nib_fix, dec_fix, is_sub, unpacked;
  logic [15:0] acc_nx;
  logic       cf_nx;

  assign lo       = acc_in[7:0];
  assign hi       = acc_in[15:8];
  assign is_sub   = op[0];
  assign unpacked = op[1];

  assign nib_fix = (lo[3:0] > 4'd9) | af_in;
  assign dec_fix = (lo > 8'h99) | cf_in;

  assign lo_step = nib_fix ? (is_sub ? lo - 8'h06 : lo + 8'h06) : lo;
  assign lo_dec  = dec_fix ? (is_sub ? lo_step - 8'h60 : lo_step + 8'h60) : lo_step;
  assign hi_unp  = nib_fix ? (is_sub ? hi - 8'h01 : hi + 8'h01) : hi;

  assign acc_nx = unpacked ? {hi_unp, 4'h0, lo_step[3:0]} : {hi, lo_dec};
  assign cf_nx  = unpacked ? nib_fix : dec_fix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_out <= '0;
      af_out  <= 1'b0;
      cf_out  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= valid_in;
      if (valid_in) begin
        acc_out <= acc_nx;
        af_out  <= nib_fix;
        cf_out  <= cf_nx;
      end
    end
  end
endmodule

// File: rtl/bcd_adjust_unit_chk.sv
module bcd_adjust_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_in,
  input logic [1:0]  op,
  input logic [15:0] acc_in,
  input logic [15:0] acc_out,
  input logic        af_out,
  input logic        cf_out,
  input logic        done
);
  p_done_after_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> done);
  p_done_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !done);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> $stable({acc_out, af_out, cf_out}));
  p_packed_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !op[1]) |=> acc_out[15:8] == $past(acc_in[15:8]));
  p_unpacked_nibble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && op[1]) |=> acc_out[7:4] == 4'h0);
  p_unpacked_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && op[1]) |=> af_out == cf_out);
endmodule

bind bcd_adjust_unit bcd_adjust_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op), .acc_in(acc_in),
  .acc_out(acc_out), .af_out(af_out), .cf_out(cf_out), .done(done)
);

// File: tb/sim_bcd_adjust_unit.sv
`timescale 1ns/1ps
module sim_bcd_adjust_unit;
  logic clk = 0, rst_n = 0, valid_in = 0, af_in = 0, cf_in = 0;
  logic [1:0] op = 0;
  logic [15:0] acc_in = 0;
  logic [15:0] acc_out;
  logic af_out, cf_out, done;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bcd_adjust_unit u0 (.clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op),
    .acc_in(acc_in), .af_in(af_in), .cf_in(cf_in), .acc_out(acc_out),
    .af_out(af_out), .cf_out(cf_out), .done(done));

  function automatic logic [17:0] model(input logic [1:0] o, input logic [15:0] a,
                                        input logic af, input logic cf);
    logic [7:0] l, h; logic na, nc, cond;
    l = a[7:0]; h = a[15:8];
    cond = (l[3:0] > 9) || af;
    na = cond; nc = 0;
    if (!o[1]) begin
      if (cond) l = o[0] ? l - 8'd6 : l + 8'd6;
      if (a[7:0] > 8'h99 || cf) begin l = o[0] ? l - 8'h60 : l + 8'h60; nc = 1; end
    end else begin
      if (cond) begin
        l = o[0] ? l - 8'd6 : l + 8'd6;
        h = o[0] ? h - 8'd1 : h + 8'd1;
        nc = 1;
      end
      l = l & 8'h0F;
    end
    return {h, l, na, nc};
  endfunction

  task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] o, input logic [15:0] a, input logic af, input logic cf,
                     input string req);
    logic [17:0] e;
    @(negedge clk);
    op = o; acc_in = a; af_in = af; cf_in = cf; valid_in = 1;
    @(negedge clk);
    valid_in = 0;
    e = model(o, a, af, cf);
    check(req, {done, acc_out, af_out, cf_out}, {1'b1, e});
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [18:0] held;
    logic [15:0] his [4] = '{16'h0000, 16'h0200, 16'h7F00, 16'hFF00};
    #35;
    check("R1 reset", {done, acc_out, af_out, cf_out}, 19'h0);
    rst_n = 1;
    // named examples
    run(2'b00, 16'h000F, 0, 0, "R4 packed add 0Fh");
    check("R4 value", {3'b0, acc_out}, {3'b0, 16'h0015});
    run(2'b01, 16'h00FF, 0, 0, "R5 packed sub FFh");
    check("R5 value", {acc_out, af_out, cf_out, 1'b0}, {16'h0099, 1'b1, 1'b1, 1'b0});
    run(2'b10, 16'h000F, 0, 0, "R6 unpacked add");
    check("R6 value", {3'b0, acc_out}, {3'b0, 16'h0105});
    run(2'b11, 16'h02FF, 0, 0, "R7 unpacked sub");
    check("R7 value", {3'b0, acc_out}, {3'b0, 16'h0109});
    run(2'b00, 16'h0034, 1, 0, "R3 AF forces digit fix");
    check("R3 value", {3'b0, acc_out}, {3'b0, 16'h003A});
    // hold and single-cycle done
    held = {1'b0, acc_out, af_out, cf_out};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      acc_in = 16'h5A5A ^ 16'(i); op = 2'(i); af_in = 1; cf_in = 1;
      check("R2 hold", {done, acc_out, af_out, cf_out}, held);
    end
    // exhaustive sweep
    for (int o = 0; o < 4; o++)
      for (int h = 0; h < 4; h++)
        for (int l = 0; l < 256; l++)
          for (int f = 0; f < 4; f++)
            run(2'(o), his[h] | 16'(l), f[1], f[0],
                o == 0 ? "R4 sweep" : o == 1 ? "R5 sweep" : o == 2 ? "R6 R8 sweep" : "R7 R8 sweep");
    @(negedge clk);
    check("R2 done drops", {18'h0, done}, 19'h0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule